// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Core with Single-Strobe Burst Control

This block models a single-port synchronous static memory. It is built for pipelines that cannot spend an idle bus cycle between a read and a write. All control is sampled on the rising clock edge, and only on edges where the active-low clock enable is low. A high clock enable freezes the block completely: the current access, the burst position and any write still waiting for its data all hold. A high clock enable does not deselect the memory.

One strobe decides what each edge does. When the strobe is low, the edge loads a fresh address and a new access starts; the write-enable level at that edge makes the access a read or a write. When the strobe is high, the edge moves on to the next word of the burst and keeps the same access type. The low address bits feed a small wrapping counter, while the upper bits stay fixed for the whole burst.

Reads are flow-through: the word appears combinationally after the edge that selects it. Write data follows one sampled edge after its address, so a read can be followed at once by a write. The data bus is split into byte lanes. Each lane has its own active-low write mask. An asynchronous output enable and the internal state together produce a single drive-enable output.

Top module: `fts_core`

## Requirements
- R1: While `clk_en_n` is high at a rising edge, nothing in the block changes: no state update, no burst step and no array write. The pending access resumes at the next edge where `clk_en_n` is low.
- R2: The memory is selected on a sampled edge only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination ends the current access and turns `dq_drive` off.
- R3: A selected edge with `load_n`=0 starts a new access at `addr`. The access is a write when `wr_n`=0 and a read when `wr_n`=1.
- R4: A selected edge with `load_n`=1 during an access advances the burst word. The word address is {upper bits of the loaded address, counter}. The counter starts from `addr[1:0]`, counts up by one and wraps 3→0. The upper bits and the access type do not change.
- R5: On a write, only the lanes whose `lane_wr_n` bit is 0 are updated. Bit i of `lane_wr_n` guards bits [9i+8:9i] of the data. The mask is captured on the edge that presents the word address (load or advance).
- R6: The write data for a word addressed on edge N is taken from `dq_in` on the next sampled edge after N, together with whatever command that edge carries.
- R7: During a read, `dq_out` shows the addressed word combinationally after the edge that addresses it. It already reflects a write that was completed on that same edge.
- R8: An advance (`load_n`=1) on a selected edge while no access is active is ignored: no access starts and `dq_drive` stays 0.
- R9: `dq_drive` is 0 in each of these cases: `out_en_n` is high; a write access is active; the memory is deselected; or the current access was loaded directly from the deselected state (its first word only).
- R10: After reset the memory is deselected and `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock qualifier; high stalls the block |
| sel_a_n | input | 1 | Select term, active low |
| sel_b | input | 1 | Select term, active high |
| sel_c_n | input | 1 | Select term, active low |
| wr_n | input | 1 | Low on a load edge makes the access a write |
| load_n | input | 1 | Low loads a new address, high advances the burst |
| lane_wr_n | input | LANES (4) | Per-lane write mask, active low |
| addr | input | ADDR_W (6) | Word address; the low BURST_W bits seed the burst counter |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W (36) | Write data |
| dq_out | output | LANES*LANE_W (36) | Read data of the current word |
| dq_drive | output | 1 | High when the data bus should be driven |

## Verification
Completing a write and issuing a new command can fall on the same edge. The data of the last word of a write burst rides on the edge that loads the next burst, or the next read. The bench provokes this by chaining write bursts back to back and by following a read directly with a write and the write with a read. A reference model in the bench, built from the requirements, commits the old word before it applies the new command, and every read word is checked against that model. Stalls placed inside a write data phase, with `dq_in` changed during the stall, show that only the data present at the resuming edge is stored.

// File: rtl/fts_pkg.sv
package fts_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/fts_burst.sv
// Burst word counter: seeded on a load edge, stepped on an advance edge.
module fts_burst #(
   parameter int BURST_W = 2,
   parameter bit LINEAR  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en_n,
   input  logic               load,
   input  logic               step,
   input  logic [BURST_W-1:0] seed,
   output logic [BURST_W-1:0] cnt
);
   generate
      if (LINEAR) begin : g_lin
         logic [BURST_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!clk_en_n) begin
               if (load)
                  cnt_q <= seed;
               else if (step)
                  cnt_q <= cnt_q + 1'b1;
            end
         end
         assign cnt = cnt_q;

         // R4: linear step, wrapping at the top
         a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
            (!clk_en_n && step && !load) |=> cnt == BURST_W'($past(cnt) + 1'b1));
      end else begin : g_ilv
         logic [BURST_W-1:0] seed_q;
         logic [BURST_W-1:0] beat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seed_q <= '0;
               beat_q <= '0;
            end else if (!clk_en_n) begin
               if (load) begin
                  seed_q <= seed;
                  beat_q <= '0;
               end else if (step)
                  beat_q <= beat_q + 1'b1;
            end
         end
         assign cnt = seed_q ^ beat_q;
      end
   endgenerate
endmodule

// File: rtl/fts_ctrl.sv
// Access control: select decode, load/advance decision, stall hold.
module fts_ctrl
   import fts_pkg::*;
#(
   parameter int HI_W  = 4,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic             sel,
   input  logic             load_n,
   input  logic             wr_n,
   input  logic [LANES-1:0] lane_wr_n,
   input  logic [HI_W-1:0]  addr_hi,
   output op_e              op,
   output logic [HI_W-1:0]  hi_q,
   output logic [LANES-1:0] lanes_q,
   output logic             fresh_q,
   output logic             do_load,
   output logic             do_step
);
   assign do_load = sel && !load_n;
   assign do_step = sel && load_n && (op != OP_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op      <= OP_IDLE;
         hi_q    <= '0;
         lanes_q <= '1;
         fresh_q <= 1'b0;
      end else if (!clk_en_n) begin
         if (!sel) begin
            op      <= OP_IDLE;
            fresh_q <= 1'b0;
         end else if (!load_n) begin
            op      <= wr_n ? OP_READ : OP_WRITE;
            hi_q    <= addr_hi;
            lanes_q <= lane_wr_n;
            fresh_q <= (op == OP_IDLE);
         end else if (op != OP_IDLE) begin
            lanes_q <= lane_wr_n;
            fresh_q <= 1'b0;
         end
      end
   end

   // R1: a masked edge leaves every control register untouched
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(op) && $stable(hi_q) && $stable(lanes_q) && $stable(fresh_q)));
   // R2: a bad select combination ends the access
   a_r2_desel: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !sel) |=> op == OP_IDLE);
   // R3: write enable on a load edge decides the access kind
   a_r3_load_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && sel && !load_n && !wr_n) |=> op == OP_WRITE);
   // R8: an advance while idle starts nothing
   a_r8_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && op == OP_IDLE && load_n) |=> op == OP_IDLE);
endmodule

// File: rtl/fts_array.sv
// Storage split into independently written byte lanes, asynchronous read.
module fts_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [LANE_W-1:0] mem_q [DEPTH];
         always_ff @(posedge clk) begin
            if (we && !lane_wr_n[l])
               mem_q[addr] <= wdata[l*LANE_W +: LANE_W];
         end
         assign rdata[l*LANE_W +: LANE_W] = mem_q[addr];
      end
   endgenerate
endmodule

// File: rtl/fts_core.sv
module fts_core
   import fts_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter bit LINEAR  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    wr_n,
   input  logic                    load_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    out_en_n,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_drive
);
   localparam int HI_W = ADDR_W - BURST_W;

   generate
      if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
         $error("fts_core: BURST_W must be at least 1 and below ADDR_W");
      end
      if (ADDR_W > 10) begin : g_bad_depth
         $error("fts_core: ADDR_W too large for a behavioural array");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("fts_core: LANES and LANE_W must be positive");
      end
   endgenerate

   logic               sel;
   op_e                op;
   logic [HI_W-1:0]    hi_q;
   logic [LANES-1:0]   lanes_q;
   logic               fresh_q;
   logic               do_load;
   logic               do_step;
   logic [BURST_W-1:0] cnt;
   logic [ADDR_W-1:0]  word_addr;
   logic               we;

   assign sel = !sel_a_n && sel_b && !sel_c_n;

   fts_ctrl #(.HI_W(HI_W), .LANES(LANES)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel(sel),
      .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
      .addr_hi(addr[ADDR_W-1:BURST_W]), .op(op), .hi_q(hi_q),
      .lanes_q(lanes_q), .fresh_q(fresh_q), .do_load(do_load), .do_step(do_step)
   );

   fts_burst #(.BURST_W(BURST_W), .LINEAR(LINEAR)) burst_i (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load(do_load),
      .step(do_step), .seed(addr[BURST_W-1:0]), .cnt(cnt)
   );

   assign word_addr = {hi_q, cnt};
   assign we        = !clk_en_n && (op == OP_WRITE);

   fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
      .clk(clk), .we(we), .lane_wr_n(lanes_q), .addr(word_addr),
      .wdata(dq_in), .rdata(dq_out)
   );

   assign dq_drive = (op == OP_READ) && !fresh_q && !out_en_n;

   // R9: bus stays quiet during a write data phase
   a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE) |-> !dq_drive);
   // R9: first word after leaving the deselected state is not driven
   a_r9_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && op == OP_IDLE && sel && !load_n) |=> !dq_drive);
endmodule

// File: tb/fts_core_tb_top.sv
`timescale 1ns/1ps
module fts_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en_n = 1'b0;
   logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic        wr_n = 1'b1, load_n = 1'b0, out_en_n = 1'b0;
   logic [3:0]  lane_wr_n = 4'hF;
   logic [5:0]  addr = '0;
   logic [35:0] dq_in = '0;
   logic [35:0] dq_out;
   logic        dq_drive;

   int n_chk = 0;
   int n_fail = 0;

   // bench reference model: 0 idle, 1 read, 2 write
   logic [35:0] mmem [64];
   int          mop = 0;
   logic [3:0]  mhi = '0;
   logic [1:0]  mcnt = '0;
   logic [3:0]  mlanes = 4'hF;
   logic        mfresh = 1'b0;

   always #2.5 clk = ~clk;

   fts_core dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
      .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n), .load_n(load_n),
      .lane_wr_n(lane_wr_n), .addr(addr), .out_en_n(out_en_n),
      .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
   );

   function automatic logic [35:0] pat(input logic [5:0] a, input int pass);
      logic [35:0] v;
      v = 36'(a) * 36'h2_4925 + 36'(pass) * 36'h9_1357 + 36'h1_0203;
      return v;
   endfunction

   function automatic logic [5:0] cur_addr();
      return {mhi, mcnt};
   endfunction

   task automatic model_edge();
      logic sel;
      logic [35:0] old;
      sel = !sel_a_n && sel_b && !sel_c_n;
      if (mop == 2) begin
         old = mmem[cur_addr()];
         for (int l = 0; l < 4; l++)
            if (!mlanes[l]) old[l*9 +: 9] = dq_in[l*9 +: 9];
         mmem[cur_addr()] = old;
      end
      if (!sel) begin
         mop = 0; mfresh = 1'b0;
      end else if (!load_n) begin
         mfresh = (mop == 0);
         mop = wr_n ? 1 : 2;
         mhi = addr[5:2]; mcnt = addr[1:0]; mlanes = lane_wr_n;
      end else if (mop != 0) begin
         mcnt = mcnt + 2'd1; mlanes = lane_wr_n; mfresh = 1'b0;
      end
   endtask

   task automatic check(input string tag);
      logic exp_drv;
      exp_drv = (mop == 1) && !mfresh && !out_en_n;
      n_chk++;
      if (dq_drive !== exp_drv) begin
         n_fail++;
         $display("FAIL %s drive act=%0b exp=%0b", tag, dq_drive, exp_drv);
      end
      if (mop == 1) begin
         n_chk++;
         if (dq_out !== mmem[cur_addr()]) begin
            n_fail++;
            $display("FAIL %s data @%0d act=%h exp=%h", tag, cur_addr(), dq_out, mmem[cur_addr()]);
         end
      end
   endtask

   task automatic step(input logic cen, input logic s_ok, input logic ld, input logic w,
                       input logic [3:0] bw, input logic [5:0] ad, input logic [35:0] din,
                       input string tag);
      clk_en_n = cen; sel_a_n = !s_ok; sel_b = s_ok; sel_c_n = !s_ok;
      load_n = ld; wr_n = w; lane_wr_n = bw; addr = ad; dq_in = din;
      @(posedge clk);
      if (!cen) model_edge();
      @(negedge clk);
      check(tag);
   endtask

   function automatic logic [35:0] wdat(input int pass);
      return pat(cur_addr(), pass);
   endfunction

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mmem[i] = '0;
      repeat (3) @(negedge clk);
      n_chk++;
      if (dq_drive !== 1'b0) begin
         n_fail++; $display("FAIL R10 drive act=%0b exp=0", dq_drive);
      end
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R10 idle");

      // full-lane write bursts back to back (R3 R6 concurrency)
      for (int b = 0; b < 16; b++) begin
         step(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 6'(b*4), wdat(0), "R3 R6 load wr");
         for (int k = 0; k < 3; k++)
            step(1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 6'd63, wdat(0), "R4 R6 adv wr");
      end
      // partial-lane write bursts with wrapping seeds (R4 R5)
      for (int b = 0; b < 16; b++) begin
         step(1'b0, 1'b1, 1'b0, 1'b0, 4'(b), 6'(b*4 + (b % 4)), wdat(0), "R5 load wr");
         for (int k = 0; k < 3; k++)
            step(1'b0, 1'b1, 1'b1, 1'b0, 4'(b + k + 1), 6'd0, wdat(1), "R4 R5 adv wr");
      end
      // read bursts, wrapping seeds; first read follows a write directly (R7)
      for (int b = 0; b < 16; b++) begin
         step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'(b*4 + ((b + 2) % 4)), wdat(1), "R7 load rd");
         for (int k = 0; k < 3; k++)
            step(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 6'd0, '0, "R4 R7 adv rd");
      end
      // first word after deselect is masked (R9), then driven
      step(1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, '0, "R2 desel");
      step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd9, '0, "R9 fresh");
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R9 fresh adv");
      // advance while deselected ignored (R8)
      step(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R2 desel");
      for (int k = 0; k < 3; k++)
         step(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 6'd0, '1, "R8 idle adv");
      step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd20, '0, "R8 load");
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R8 adv");
      // stall during read (R1)
      for (int k = 0; k < 3; k++)
         step(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'(k), '1, "R1 stall rd");
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R1 resume rd");
      // stall during write data phase, changing data (R1 R6)
      step(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 6'd33, '0, "R1 load wr");
      for (int k = 0; k < 3; k++)
         step(1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 6'd7, 36'(k + 1) * 36'h1_1111, "R1 stall wr");
      step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd33, 36'h5_A5A5_A5A5, "R1 R6 wr then rd");
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R7 rd adv");
      // output enable high masks (R9)
      out_en_n = 1'b1;
      step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd40, '0, "R9 oe high");
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R9 oe high adv");
      out_en_n = 1'b0;
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R9 oe low");
      // each bad select combination ends a read burst (R2)
      for (int c = 0; c < 8; c++) begin
         if (c == 2) continue;
         step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'(c * 5), '0, "R2 load");
         step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R2 adv");
         clk_en_n = 1'b0; sel_a_n = c[0]; sel_b = c[1]; sel_c_n = c[2];
         load_n = 1'b1; wr_n = 1'b1;
         @(posedge clk); model_edge(); @(negedge clk);
         check("R2 bad combo");
         step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R2 R8 after");
      end
      // read then write then read turnaround (R6 R7)
      step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd50, '0, "R7 rd");
      step(1'b0, 1'b1, 1'b0, 1'b0, 4'h5, 6'd50, '0, "R6 wr after rd");
      step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd50, 36'hF_0F0F_0F0F, "R5 R6 rd after wr");
      step(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0, '0, "R2 end");

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule